// File: doc/BRIEF.md
# Auto-Reload Square-Wave Timer

This block is a 16-bit up-counter that restarts from a programmable reload value each time it passes its all-ones state. Every such restart flips an internal toggle bit. When the block runs as a timer with its output enabled, that toggle bit drives the output pin as a clean square wave. The counter advances once every two system clocks. Each half-period of the wave is therefore `2 × (65536 − reload)` clocks long, and the output frequency is `f_clk / (4 × (65536 − reload))`. At a 16 MHz system clock this gives a range from about 61 Hz up to 4 MHz.

Each restart also sends out a one-cycle baud tick for a serial unit elsewhere on the chip. The baud tick and the square wave come from the same reload value, so their rates always stay in a fixed ratio. In clock-out mode a restart does not raise the timer interrupt pulse. In plain timer mode it does.

Software controls the block through an 8-bit write port with four addresses:
- a mode register,
- the low reload byte,
- the high reload byte,
- the pin's ordinary port-latch bit.

When the output is not enabled, the pin shows the port-latch bit.

Top module: `tco_clkout_gen`

## Requirements
- R1: After reset the counter, the reload value and all mode bits are 0, the port latch and the toggle bit are 1, so the pin is high and no tick or interrupt pulse is present.
- R2: While counting is enabled, the counter advances by one every 2 system clocks, and the prescale phase is kept across stops.
- R3: When the counter advances from all-ones, it loads the reload value and the toggle bit flips. The high and low halves of the wave are each `2 × (65536 − reload)` clocks long (reload FFFFh gives 2, FF00h gives 512).
- R4: Clock-out mode is active exactly when the count-select bit is 0 and the output-enable bit is 1. In that mode the pin carries the toggle bit; otherwise the pin carries the port-latch bit.
- R5: With the run bit at 0, the counter and prescale phase hold, no tick occurs and the wave stops in its current level.
- R6: `ovf_irq` pulses for one cycle on a restart only if clock-out mode was not active. In clock-out mode no restart produces it.
- R7: `baud_tick` pulses for one cycle on every restart, whether or not the output is enabled, and so runs at twice the square-wave frequency.
- R8: Writing a reload byte does not change the counter. The new value is first used at the next restart.
- R9: With the count-select bit at 1 (external counting, not implemented here), the counter does not advance and no tick occurs.
- R10: Writes happen only on a clock with `wr_en` high. The addresses are:
  - 0: mode register, with bit0 = run, bit1 = output enable and bit2 = count select;
  - 1: reload low byte;
  - 2: reload high byte;
  - 3: port latch, in bit0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| clk_pin | output | 1 | Square wave or port-latch value |
| baud_tick | output | 1 | One-cycle pulse per restart |
| ovf_irq | output | 1 | One-cycle timer interrupt pulse, suppressed in clock-out mode |

## Verification
The checker's assertions cover these behaviours on every cycle:
- the counter picks up the previous reload value exactly when a tick appears;
- the toggle bit changes only together with a tick;
- an interrupt pulse only comes with a tick and never after a cycle in clock-out mode;
- a stopped counter or one set to external counting neither moves nor ticks.

Only the bench's scenarios can show these:
- the actual half-period lengths for several reload values;
- the deferred effect of a reload write;
- the pin falling back to the port latch;
- writes being ignored without the strobe.

A behavioural reference model, compared on every clock, covers the rest.

// File: rtl/tco_pkg.sv
package tco_pkg;

    typedef enum logic [1:0] {
        REG_MODE      = 2'd0,
        REG_RELOAD_LO = 2'd1,
        REG_RELOAD_HI = 2'd2,
        REG_PORT      = 2'd3
    } tco_addr_e;

    localparam int MODE_RUN_BIT = 0;
    localparam int MODE_OE_BIT  = 1;
    localparam int MODE_CT_BIT  = 2;

    typedef struct packed {
        logic ct_sel;
        logic oe;
        logic run;
    } tco_mode_t;

endpackage

// File: rtl/tco_regs.sv
module tco_regs
    import tco_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    output tco_mode_t             mode_o,
    output logic [2*BYTE_W-1:0]   reload_o,
    output logic                  port_o
);

    typedef struct packed {
        tco_mode_t         mode;
        logic [BYTE_W-1:0] rel_hi;
        logic [BYTE_W-1:0] rel_lo;
        logic              port;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (tco_addr_e'(wr_addr))
                REG_MODE: begin
                    st_d.mode.run    = wr_data[MODE_RUN_BIT];
                    st_d.mode.oe     = wr_data[MODE_OE_BIT];
                    st_d.mode.ct_sel = wr_data[MODE_CT_BIT];
                end
                REG_RELOAD_LO: st_d.rel_lo = wr_data;
                REG_RELOAD_HI: st_d.rel_hi = wr_data;
                REG_PORT:      st_d.port   = wr_data[0];
                default:       st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: '0, rel_hi: '0, rel_lo: '0, port: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o   = st_q.mode;
    assign reload_o = {st_q.rel_hi, st_q.rel_lo};
    assign port_o   = st_q.port;

endmodule

// File: rtl/tco_counter.sv
module tco_counter #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             roll_o,
    output logic             tick_o
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step;
    logic    roll;

    always_comb begin
        st_d = st_q;
        step = count_en && (st_q.pre == PRE_LAST);
        roll = step && (&st_q.cnt);
        if (count_en) begin
            st_d.pre = step ? '0 : PRE_W'(st_q.pre + 1'b1);
        end
        if (roll) begin
            st_d.cnt = reload_i;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.tick = roll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign roll_o = roll;
    assign tick_o = st_q.tick;

endmodule

// File: rtl/tco_outmux.sv
module tco_outmux (
    input  logic clk,
    input  logic rst_n,
    input  logic roll_i,
    input  logic clkout_mode_i,
    input  logic port_i,
    output logic pin_o,
    output logic tog_o,
    output logic ovf_o
);

    typedef struct packed {
        logic tog;
        logic ovf;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tog = roll_i ? ~st_q.tog : st_q.tog;
        st_d.ovf = roll_i && !clkout_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tog: 1'b1, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = clkout_mode_i ? st_q.tog : port_i;
    assign tog_o = st_q.tog;
    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/tco_clkout_gen.sv
module tco_clkout_gen
    import tco_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRESCALE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              clk_pin,
    output logic              baud_tick,
    output logic              ovf_irq
);

    localparam int CNT_W = 2 * BYTE_W;

    tco_mode_t        mode_q;
    logic [CNT_W-1:0] reload_q;
    logic             port_q;
    logic [CNT_W-1:0] cnt_q;
    logic             roll;
    logic             tog_q;
    logic             count_en;
    logic             clkout_mode;

    assign count_en    = mode_q.run && !mode_q.ct_sel;
    assign clkout_mode = !mode_q.ct_sel && mode_q.oe;

    tco_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode_o   (mode_q),
        .reload_o (reload_q),
        .port_o   (port_q)
    );

    tco_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .reload_i (reload_q),
        .cnt_o    (cnt_q),
        .roll_o   (roll),
        .tick_o   (baud_tick)
    );

    tco_outmux u_outmux (
        .clk           (clk),
        .rst_n         (rst_n),
        .roll_i        (roll),
        .clkout_mode_i (clkout_mode),
        .port_i        (port_q),
        .pin_o         (clk_pin),
        .tog_o         (tog_q),
        .ovf_o         (ovf_irq)
    );

endmodule

// File: rtl/tco_clkout_chk.sv
module tco_clkout_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             oe,
    input logic             ct_sel,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] cnt,
    input logic             tog,
    input logic             tick,
    input logic             ovf
);

    // R3: a restart loads the reload value held before that edge
    a_r3_reload_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt == $past(reload)));

    // R3: the toggle bit only flips together with a restart tick
    a_r3_toggle_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tog != $past(tog)) |-> tick);

    // R5: a stopped counter holds its value and emits no tick
    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> ((cnt == $past(cnt)) && !tick));

    // R6: interrupt pulse needs a restart
    a_r6_ovf_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> tick);

    // R6: no interrupt pulse out of a clock-out-mode cycle
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(ct_sel) || !$past(oe)));

    // R9: count select set means no advance
    a_r9_no_count_external: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ct_sel) |-> (!tick && (cnt == $past(cnt))));

endmodule

bind tco_clkout_gen tco_clkout_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (mode_q.run),
    .oe     (mode_q.oe),
    .ct_sel (mode_q.ct_sel),
    .reload (reload_q),
    .cnt    (cnt_q),
    .tog    (tog_q),
    .tick   (baud_tick),
    .ovf    (ovf_irq)
);

// File: tb/tco_clkout_gen_test.sv
module tco_clkout_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       clk_pin;
    logic       baud_tick;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int   m_cnt, m_pre, m_rel;
    logic m_run, m_oe, m_ct, m_port, m_tog, m_tick, m_ovf;
    logic m_roll, m_cm;

    // observation helpers
    int since = 0;
    int last_gap = 0;
    int tick_cnt = 0;
    int ovf_cnt = 0;

    always #10 clk = ~clk;

    tco_clkout_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clk_pin   (clk_pin),
        .baud_tick (baud_tick),
        .ovf_irq   (ovf_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: prescale of 2, 16-bit counter
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_rel = 0;
            m_run = 0; m_oe = 0; m_ct = 0;
            m_port = 1; m_tog = 1; m_tick = 0; m_ovf = 0;
        end else begin
            m_roll = 1'b0;
            m_cm   = !m_ct && m_oe;
            if (m_run && !m_ct) begin
                if (m_pre == 1) begin
                    m_pre = 0;
                    if (m_cnt == 65535) begin
                        m_roll = 1'b1;
                        m_cnt  = m_rel;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            m_tick = m_roll;
            m_ovf  = m_roll && !m_cm;
            if (m_roll) m_tog = !m_tog;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_run = wr_data[0]; m_oe = wr_data[1]; m_ct = wr_data[2]; end
                    2'd1: m_rel = (m_rel & 32'hFF00) | int'(wr_data);
                    2'd2: m_rel = (m_rel & 32'h00FF) | (int'(wr_data) << 8);
                    default: m_port = wr_data[0];
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #5;
        cycles++;
        if (rst_n) begin
            check(clk_pin === ((!m_ct && m_oe) ? m_tog : m_port), "R4 pin vs model",
                  int'(clk_pin), int'((!m_ct && m_oe) ? m_tog : m_port));
            check(baud_tick === m_tick, "R7 tick vs model", int'(baud_tick), int'(m_tick));
            check(ovf_irq === m_ovf, "R6 ovf vs model", int'(ovf_irq), int'(m_ovf));
            if (baud_tick === 1'b1) begin
                last_gap = since;
                since    = 1;
                tick_cnt++;
            end else begin
                since++;
            end
            if (ovf_irq === 1'b1) ovf_cnt++;
        end
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        do begin
            @(posedge clk);
            #6;
        end while (baud_tick !== 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #6;
    endtask

    int t0;
    logic p0;

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        idle(2);
        // R1: reset state
        check(clk_pin === 1'b1, "R1 pin high after reset", int'(clk_pin), 1);
        check(baud_tick === 1'b0, "R1 no tick after reset", int'(baud_tick), 0);
        check(ovf_irq === 1'b0, "R1 no ovf after reset", int'(ovf_irq), 0);

        // R10: configure reload FF00, run + output enable
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h03);
        ovf_cnt = 0;
        wait_tick();   // first restart from zero
        check(clk_pin === 1'b0, "R3 first restart toggles pin low", int'(clk_pin), 0);
        wait_tick();
        check(last_gap == 512, "R3 low half at FF00", last_gap, 512);
        check(clk_pin === 1'b1, "R3 pin high again", int'(clk_pin), 1);
        wait_tick();
        check(last_gap == 512, "R3 high half at FF00 (50% duty)", last_gap, 512);
        check(ovf_cnt == 0, "R6 no ovf in clock-out mode", ovf_cnt, 0);

        // R8: reload change only used at the next restart
        wait_tick();
        wr(2'd1, 8'hF0);
        wait_tick();
        check(last_gap == 512, "R8 old count finishes", last_gap, 512);
        wait_tick();
        check(last_gap == 32, "R8 new reload FFF0 used", last_gap, 32);

        // R10: write without strobe is ignored
        @(negedge clk);
        wr_addr = 2'd0; wr_data = 8'h00;
        idle(5);
        wait_tick();
        wait_tick();
        check(last_gap == 32, "R10 unstrobed stop ignored", last_gap, 32);

        // R3/R7: fastest setting FFFF
        wr(2'd1, 8'hFF);
        wait_tick(); wait_tick(); wait_tick();
        check(last_gap == 2, "R3 half period 2 at FFFF", last_gap, 2);
        t0 = tick_cnt;
        idle(40);
        check(tick_cnt - t0 == 20, "R7 tick every restart", tick_cnt - t0, 20);

        // R2: mid-range reload checks the 2-clock increment
        wr(2'd1, 8'hFA);
        wait_tick(); wait_tick();
        check(last_gap == 12, "R2 two clocks per count (6 counts)", last_gap, 12);

        // R4/R6: output disabled, pin follows port latch, ovf appears
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h01);
        idle(2);
        check(clk_pin === 1'b0, "R4 pin follows port latch 0", int'(clk_pin), 0);
        ovf_cnt = 0; t0 = tick_cnt;
        idle(60);
        check(ovf_cnt == tick_cnt - t0 && ovf_cnt > 0, "R6 ovf in timer mode", ovf_cnt, tick_cnt - t0);
        wr(2'd3, 8'h01);
        idle(1);
        check(clk_pin === 1'b1, "R4 pin follows port latch 1", int'(clk_pin), 1);

        // R5: stop holds everything
        wr(2'd0, 8'h02);
        idle(2);
        t0 = tick_cnt; p0 = clk_pin;
        idle(100);
        check(tick_cnt == t0, "R5 no tick while stopped", tick_cnt - t0, 0);
        check(clk_pin === p0, "R5 wave frozen", int'(clk_pin), int'(p0));
        wr(2'd0, 8'h03);
        wait_tick(); wait_tick();
        check(last_gap == 12, "R5 resumes with same period", last_gap, 12);

        // R9: count select set, no counting, pin shows latch
        wr(2'd0, 8'h07);
        idle(2);
        t0 = tick_cnt;
        idle(50);
        check(tick_cnt == t0, "R9 no tick with count select", tick_cnt - t0, 0);
        check(clk_pin === 1'b1, "R9 R4 pin shows latch", int'(clk_pin), 1);
        wr(2'd0, 8'h03);
        wait_tick(); wait_tick();
        check(last_gap == 12, "R9 timer resumes", last_gap, 12);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule